// File: doc/BRIEF.md
# Event Readout Controller with Timestamp

This controller services a group of front-end chips that share an open-collector style service-request line. When a chip pulls the line active, the controller records the value of a free-running timestamp counter and then drives the line active itself for the whole readout. While the line is held, the chips freeze their trigger state. The controller then waits a programmable number of cycles so that the analog peak detectors reach their maximum. After that wait it toggles a readout clock and shifts in one serial word from each chip's data line.

Clocking stops when every chip reports end of conversion, or when a timeout expires, which also sets an error bit. The controller then lets go of the request line and, one cycle later, pulses a reset to the chips. The event leaves on a valid/ready stream: first the timestamp, then one word per chip, then a trailer that carries the error bit and the number of readout pulses. A new event is only accepted once the request line has been seen idle for a minimum number of consecutive cycles.

Top module: `erc_top`

## Requirements
- R1: While `rst` is high and in the cycle after it, `req_drive_o`, `rdclk_o`, `chip_rst_o` and `m_valid_o` are all 0.
- R2: In the idle state, a cycle where `req_in` is 1 and was 0 for at least IDLE_MIN (2) consecutive cycles before it starts an event. `req_drive_o` is 1 from the next cycle until collection ends.
- R3: The first stream word is the value of a TS_W-bit free-running counter at the cycle the event was sampled. The difference between the first words of two events equals the number of cycles between their request edges.
- R4: The first rising edge of `rdclk_o` comes S+1 cycles after the cycle that samples the request edge. S is `settle_i`, and when `settle_i` is 0, S is SETTLE_DEF (200).
- R5: `rdclk_o` is high for one cycle and low for at least one cycle. Each chip's bit is sampled in the cycle where `rdclk_o` goes from 1 to 0. The bits are shifted in MSB first, and a chip word holds the last WORD_W bits sampled, in the low bits of its stream word.
- R6: Clocking ends when all `eoc_i` bits are 1. The trailer then has bit TS_W-1 = 0 and holds the count of completed readout pulses in its low bits.
- R7: If not all `eoc_i` bits are 1 within TMO_CYC (default 4096) clocking cycles, clocking stops. The trailer then has bit TS_W-1 = 1 and pulse count (TMO_CYC-1)/2.
- R8: When collection ends, `req_drive_o` falls first. In the next cycle `chip_rst_o` rises and stays high for exactly RST_LEN (4) cycles. `rdclk_o` is never high while `req_drive_o` is low.
- R9: The stream carries, in order: the timestamp, chip 0 to chip NCHIP-1, then the trailer with `m_last_o` = 1. `m_valid_o`, `m_data_o` and `m_last_o` hold still while `m_ready_i` is 0, and `m_valid_o` is never 1 while `req_drive_o` is 1.
- R10: Request edges that come during an event, or after fewer than IDLE_MIN idle cycles, start no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 1 | Sampled level of the shared request line (1 = active) |
| settle_i | input | SETTLE_W | Peak-settling wait in cycles, 0 selects SETTLE_DEF |
| sdata_i | input | NCHIP | Serial data, one bit per chip |
| eoc_i | input | NCHIP | End-of-conversion flag, one bit per chip |
| req_drive_o | output | 1 | Drives the request line active while held |
| rdclk_o | output | 1 | Readout clock to the chips |
| chip_rst_o | output | 1 | Reset pulse to the chips |
| m_valid_o | output | 1 | Stream word valid |
| m_ready_i | input | 1 | Stream word accepted |
| m_data_o | output | TS_W | Stream word |
| m_last_o | output | 1 | Marks the trailer word |

## Verification
A wrong sequencer state shows at the ports within one cycle. The request-line drive, the readout clock or the reset pulse comes early, comes late, or appears in the wrong order, so the bench counts edges on those pins against the settle value and the pulse length. A fault in the counting logic shows up later, in the stream words. A bad shift or a bad lane index gives a wrong chip word, a bad pulse counter or timeout gives a wrong trailer, and a bad timestamp gives a wrong gap between events. The bench compares each of these words with values computed from the bit patterns and cycle counts it drove.

// File: rtl/erc_pkg.sv
package erc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_CLOCK,
    ST_REL,
    ST_RSTP,
    ST_SEND
  } erc_state_e;
endpackage

// File: rtl/erc_tstamp.sv
module erc_tstamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] ts
);
  always_ff @(posedge clk) begin
    if (rst) ts <= '0;
    else     ts <= ts + 1'b1;
  end
endmodule

// File: rtl/erc_lane.sv
module erc_lane #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clr)    word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], din};
  end
endmodule

// File: rtl/erc_top.sv
module erc_top
  import erc_pkg::*;
#(
  parameter int NCHIP      = 4,
  parameter int WORD_W     = 16,
  parameter int TS_W       = 32,
  parameter int SETTLE_W   = 16,
  parameter int SETTLE_DEF = 200,
  parameter int TMO_CYC    = 4096,
  parameter int RST_LEN    = 4,
  parameter int IDLE_MIN   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_in,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [NCHIP-1:0]    sdata_i,
  input  logic [NCHIP-1:0]    eoc_i,
  output logic                req_drive_o,
  output logic                rdclk_o,
  output logic                chip_rst_o,
  output logic                m_valid_o,
  input  logic                m_ready_i,
  output logic [TS_W-1:0]     m_data_o,
  output logic                m_last_o
);
  localparam int TMO_W  = $clog2(TMO_CYC + 1);
  localparam int RST_W  = $clog2(RST_LEN + 1);
  localparam int IDLE_W = $clog2(IDLE_MIN + 1);
  localparam int NWORD  = NCHIP + 2;
  localparam int IDX_W  = $clog2(NWORD);

  erc_state_e          state;
  logic [TS_W-1:0]     ts_now, ts_lat;
  logic [IDLE_W-1:0]   idle_cnt;
  logic [SETTLE_W-1:0] settle_eff, settle_lat, wcnt;
  logic [TMO_W-1:0]    tcnt, pulses;
  logic [RST_W-1:0]    rcnt;
  logic [IDX_W-1:0]    widx, nidx;
  logic                phase, err;
  logic                evt, done_now, shift_en;
  logic [WORD_W-1:0]   lane_word [NCHIP];
  logic [TS_W-1:0]     words [NWORD];

  erc_tstamp #(.TS_W(TS_W)) u_ts (.clk(clk), .rst(rst), .ts(ts_now));

  // Line idle history: counts consecutive low samples, saturating
  always_ff @(posedge clk) begin
    if (rst || req_in)                          idle_cnt <= '0;
    else if (idle_cnt != IDLE_W'(IDLE_MIN))     idle_cnt <= idle_cnt + 1'b1;
  end

  assign settle_eff = (settle_i == '0) ? SETTLE_W'(SETTLE_DEF) : settle_i;
  assign evt      = (state == ST_IDLE) && req_in && (idle_cnt == IDLE_W'(IDLE_MIN));
  assign done_now = (&eoc_i) || (tcnt == TMO_W'(TMO_CYC - 1));
  assign shift_en = (state == ST_CLOCK) && phase && !done_now;
  assign nidx     = widx + 1'b1;

  generate
    for (genvar i = 0; i < NCHIP; i++) begin : g_lane
      erc_lane #(.WORD_W(WORD_W)) u_lane (
        .clk(clk), .rst(rst), .clr(evt), .shift_en(shift_en),
        .din(sdata_i[i]), .word(lane_word[i])
      );
      assign words[i+1] = TS_W'(lane_word[i]);
    end
  endgenerate

  always_comb begin
    words[0]       = ts_lat;
    words[NWORD-1] = '0;
    words[NWORD-1][TS_W-1]  = err;
    words[NWORD-1][TMO_W-1:0] = pulses;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      ts_lat      <= '0;
      settle_lat  <= '0;
      wcnt        <= '0;
      tcnt        <= '0;
      pulses      <= '0;
      rcnt        <= '0;
      widx        <= '0;
      phase       <= 1'b0;
      err         <= 1'b0;
      req_drive_o <= 1'b0;
      rdclk_o     <= 1'b0;
      chip_rst_o  <= 1'b0;
      m_valid_o   <= 1'b0;
      m_data_o    <= '0;
      m_last_o    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (evt) begin
          ts_lat      <= ts_now;
          settle_lat  <= settle_eff;
          req_drive_o <= 1'b1;
          wcnt        <= '0;
          tcnt        <= '0;
          pulses      <= '0;
          phase       <= 1'b0;
          err         <= 1'b0;
          state       <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (wcnt == settle_lat - 1'b1) state <= ST_CLOCK;
          else                           wcnt  <= wcnt + 1'b1;
        end
        ST_CLOCK: begin
          if (done_now) begin
            err         <= ~(&eoc_i);
            rdclk_o     <= 1'b0;
            req_drive_o <= 1'b0;
            state       <= ST_REL;
          end else begin
            tcnt    <= tcnt + 1'b1;
            phase   <= ~phase;
            rdclk_o <= ~phase;
            if (phase) pulses <= pulses + 1'b1;
          end
        end
        ST_REL: begin
          chip_rst_o <= 1'b1;
          rcnt       <= '0;
          state      <= ST_RSTP;
        end
        ST_RSTP: begin
          if (rcnt == RST_W'(RST_LEN - 1)) begin
            chip_rst_o <= 1'b0;
            widx       <= '0;
            m_valid_o  <= 1'b1;
            m_data_o   <= words[0];
            m_last_o   <= 1'b0;
            state      <= ST_SEND;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        ST_SEND: if (m_valid_o && m_ready_i) begin
          if (m_last_o) begin
            m_valid_o <= 1'b0;
            m_last_o  <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            widx     <= nidx;
            m_data_o <= words[nidx];
            m_last_o <= (nidx == IDX_W'(NWORD - 1));
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/erc_chk.sv
module erc_chk #(
  parameter int RST_LEN = 4,
  parameter int TS_W    = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_in,
  input logic            req_drive_o,
  input logic            rdclk_o,
  input logic            chip_rst_o,
  input logic            m_valid_o,
  input logic            m_ready_i,
  input logic [TS_W-1:0] m_data_o,
  input logic            m_last_o
);
  localparam int HC_W = $clog2(RST_LEN + 2);
  logic [HC_W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)             hi_cnt <= '0;
    else if (chip_rst_o) hi_cnt <= hi_cnt + 1'b1;
    else                 hi_cnt <= '0;
  end

  // R2: drive rises only after an idle-to-active request transition
  a_r2_drive_after_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(req_drive_o) |-> $past(req_in) && !$past(req_in, 2));

  // R5: readout clock high for a single cycle
  a_r5_clk_one_high: assert property (@(posedge clk) disable iff (rst)
    rdclk_o |=> !rdclk_o);

  // R8: no readout clock unless the line is held
  a_r8_clk_needs_hold: assert property (@(posedge clk) disable iff (rst)
    rdclk_o |-> req_drive_o);

  // R8: release happens one cycle before reset
  a_r8_release_first: assert property (@(posedge clk) disable iff (rst)
    $rose(chip_rst_o) |-> !req_drive_o && $past(!req_drive_o) && $past(req_drive_o, 2));

  // R8: reset pulse length bounded and exact
  a_r8_rst_bounded: assert property (@(posedge clk) disable iff (rst)
    chip_rst_o |-> hi_cnt < HC_W'(RST_LEN));
  a_r8_rst_exact: assert property (@(posedge clk) disable iff (rst)
    $fell(chip_rst_o) |-> hi_cnt == HC_W'(RST_LEN));

  // R9: stream words hold under backpressure
  a_r9_stream_hold: assert property (@(posedge clk) disable iff (rst)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_last_o));

  // R9: no stream output while the line is held
  a_r9_no_send_busy: assert property (@(posedge clk) disable iff (rst)
    m_valid_o |-> !req_drive_o);
endmodule

bind erc_top erc_chk #(.RST_LEN(RST_LEN), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst(rst), .req_in(req_in), .req_drive_o(req_drive_o),
  .rdclk_o(rdclk_o), .chip_rst_o(chip_rst_o), .m_valid_o(m_valid_o),
  .m_ready_i(m_ready_i), .m_data_o(m_data_o), .m_last_o(m_last_o)
);

// File: tb/sim_erc_top.sv
module sim_erc_top;
  localparam int NCHIP = 2;
  localparam int W     = 8;
  localparam int TSW   = 32;
  localparam int TMO   = 64;
  localparam int SDEF  = 200;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             chip_req = 1'b0;
  logic             req_in;
  logic [15:0]      settle_i = '0;
  logic [NCHIP-1:0] sdata, eoc;
  logic             req_drive_o, rdclk_o, chip_rst_o;
  logic             m_valid_o, m_ready_i = 1'b1, m_last_o;
  logic [TSW-1:0]   m_data_o;

  int checks = 0, fails = 0, cyc = 0;
  logic [W-1:0] pat [NCHIP];
  int  bidx [NCHIP];
  bit  eoc_en = 1'b1;
  bit  hold = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign req_in = chip_req | req_drive_o;

  erc_top #(.NCHIP(NCHIP), .WORD_W(W), .TS_W(TSW), .SETTLE_W(16),
            .SETTLE_DEF(SDEF), .TMO_CYC(TMO), .RST_LEN(4), .IDLE_MIN(2)) u0 (
    .clk(clk), .rst(rst), .req_in(req_in), .settle_i(settle_i),
    .sdata_i(sdata), .eoc_i(eoc), .req_drive_o(req_drive_o),
    .rdclk_o(rdclk_o), .chip_rst_o(chip_rst_o), .m_valid_o(m_valid_o),
    .m_ready_i(m_ready_i), .m_data_o(m_data_o), .m_last_o(m_last_o)
  );

  // Chip models: advance one bit per falling readout clock
  initial for (int c = 0; c < NCHIP; c++) bidx[c] = 0;
  always @(negedge rdclk_o) for (int c = 0; c < NCHIP; c++) bidx[c] = bidx[c] + 1;
  always @(posedge chip_rst_o) for (int c = 0; c < NCHIP; c++) bidx[c] = 0;
  always @* begin
    for (int c = 0; c < NCHIP; c++) begin
      sdata[c] = (bidx[c] < W) ? pat[c][W-1-bidx[c]] : 1'b1;
      eoc[c]   = eoc_en && (bidx[c] >= W);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic raise(output int rc);
    @(negedge clk);
    chip_req = 1'b1;
    rc = cyc;
  endtask

  task automatic readout(input int s_eff, input bit tmo, input int bp, output logic [TSW-1:0] ts);
    int n = 0, k = 0, got = 0;
    logic [TSW-1:0] w;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) chk(req_drive_o == 1'b1, "R2 drive after edge", req_drive_o, 1);
    end while (!rdclk_o && n < 5000);
    chk(n == s_eff + 2, "R4 settle wait", n, s_eff + 2);
    while (req_drive_o) @(negedge clk);
    chk(!chip_rst_o && !rdclk_o, "R8 release before reset", chip_rst_o, 0);
    @(negedge clk);
    while (chip_rst_o) begin
      k++;
      if (!hold) chip_req = 1'b0;
      @(negedge clk);
    end
    chk(k == 4, "R8 reset length", k, 4);
    for (int i = 0; i < NCHIP + 2; i++) begin
      forever begin
        m_ready_i = (bp != 0) ? ((cyc % bp) != 0) : 1'b1;
        if (m_valid_o && m_ready_i) break;
        @(negedge clk);
      end
      w = m_data_o;
      if (i == 0) ts = w;
      else if (i <= NCHIP) begin
        logic [W-1:0] e;
        e = tmo ? {W{1'b1}} : pat[i-1];
        chk(w == TSW'(e), "R5 chip word", w, e);
      end else begin
        logic [TSW-1:0] e;
        e = tmo ? ((32'h1 << (TSW-1)) | TSW'((TMO-1)/2)) : TSW'(W);
        chk(w == e, tmo ? "R7 timeout trailer" : "R6 eoc trailer", w, e);
      end
      chk(m_last_o == (i == NCHIP + 1), "R9 last flag", m_last_o, i == NCHIP + 1);
      got++;
      @(negedge clk);
    end
    m_ready_i = 1'b1;
    chk(!m_valid_o, "R9 stream ends", m_valid_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int rc1, rc2, rc3, rc4, n;
    logic [TSW-1:0] t1, t2, t3, t4;
    bit seen;
    pat[0] = 8'hA5; pat[1] = 8'h3C;
    repeat (3) @(negedge clk);
    chk(!req_drive_o && !rdclk_o && !chip_rst_o && !m_valid_o, "R1 during reset",
        {req_drive_o, rdclk_o, chip_rst_o, m_valid_o}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!req_drive_o && !rdclk_o && !chip_rst_o && !m_valid_o, "R1 after reset",
        {req_drive_o, rdclk_o, chip_rst_o, m_valid_o}, 0);
    repeat (5) @(negedge clk);

    // Event 1: short settle, eoc end
    settle_i = 16'd3;
    raise(rc1);
    readout(3, 1'b0, 0, t1);

    // Event 2: longer settle, backpressure, edge during event ignored
    repeat (7) @(negedge clk);
    pat[0] = 8'h81; pat[1] = 8'h7E; settle_i = 16'd10;
    raise(rc2);
    readout(10, 1'b0, 3, t2);
    chk(t2 - t1 == TSW'(rc2 - rc1), "R3 timestamp gap 1-2", t2 - t1, rc2 - rc1);

    // Event 3: default settle, timeout, chip keeps the line high after reset
    repeat (4) @(negedge clk);
    eoc_en = 1'b0; hold = 1'b1; settle_i = 16'd0;
    raise(rc3);
    readout(SDEF, 1'b1, 0, t3);
    chk(t3 - t1 == TSW'(rc3 - rc1), "R3 timestamp gap 1-3", t3 - t1, rc3 - rc1);

    // R10: one idle cycle then active again: no event
    eoc_en = 1'b1; hold = 1'b0; settle_i = 16'd1;
    pat[0] = 8'h00; pat[1] = 8'hFF;
    repeat (3) @(negedge clk);
    chip_req = 1'b0;
    @(negedge clk); chip_req = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (req_drive_o || rdclk_o) seen = 1'b1;
    end
    chk(!seen, "R10 short idle ignored", seen, 0);

    // Two idle cycles then active: event accepted
    chip_req = 1'b0;
    @(negedge clk);
    @(negedge clk); chip_req = 1'b1; rc4 = cyc;
    readout(1, 1'b0, 0, t4);
    chk(t4 - t1 == TSW'(rc4 - rc1), "R3 timestamp gap 1-4", t4 - t1, rc4 - rc1);

    // Nothing further happens once the line is idle
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (req_drive_o || m_valid_o || chip_rst_o) n++;
    end
    chk(n == 0, "R10 quiet after event", n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule